// File: doc/BRIEF.md
# Double-Buffered Two-Channel PWM Slice

This block is one pulse-width modulation slice. A 16-bit counter runs in one of two shapes. In the sawtooth shape it climbs from zero to a programmable ceiling and then restarts at zero. In the up/down shape it climbs to the ceiling and then descends back to zero. Two outputs, A and B, each compare the counter against a threshold of their own. An output is high while the counter is below its threshold, so the threshold sets the duty cycle. In the up/down shape the resulting pulse is centred.

The ceiling and both thresholds are written through a simple one-cycle write port into holding (shadow) registers. While the slice is enabled, the held values replace the working values only at the period boundary. In sawtooth mode that boundary is the cycle where the counter sits at the ceiling and is about to restart. In up/down mode it is the cycle where the counter sits at zero. A running waveform therefore never sees a half-updated period. While the slice is disabled, the counter is frozen and every written value becomes the working value on the next clock edge.

Top module: `pwm_dual_slice`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter, the direction, all shadow values and all working values are cleared. After reset, `count` reads 0 and both outputs are low.
- R2: With `en`=1 and `phase_mode`=0, `count` advances by one per clock. In the cycle after `count` equals the working ceiling, it reads 0, so the period is ceiling+1 cycles.
- R3: `out_a` is high exactly while `count` is below the working A threshold, and `out_b` likewise uses the working B threshold. A threshold of 0 keeps the output low. A threshold above the ceiling keeps it high for the whole period.
- R4: With `en`=1 and `phase_mode`=1, the counter goes 0,1,…,ceiling,ceiling−1,…,1,0,1,… with no repeated value at either turn. The period is 2×ceiling cycles.
- R5: In sawtooth mode while enabled, a written ceiling or threshold stays in the shadow register. It becomes the working value only at the clock edge where `count` equals the working ceiling, and so it governs the period that starts at 0.
- R6: In up/down mode while enabled, shadow values become working values only at the clock edge where `count` is 0. They do not transfer at the ceiling.
- R7: While `en`=0, a written value is the working value from the next clock edge onward.
- R8: `wr_sel` selects the target of a write when `wr_en`=1: 0 writes threshold A from `wr_data_a`; 1 writes threshold B from `wr_data_a`; 2 writes A from `wr_data_a` and B from `wr_data_b` together; 3 writes the ceiling from `wr_data_a`. Registers that are not selected keep their values.
- R9: A write made in the same cycle as a transfer point is carried through the transfer, and the new value governs the following period.
- R10: While `en`=0, `count` holds its value. When `en` returns to 1, counting resumes from the held value.
- R11: With a working ceiling of 0, `count` stays at 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | 1 runs the counter; 0 freezes it and makes writes take effect at once |
| phase_mode | input | 1 | 0 sawtooth, 1 up/down |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 2 | Write target: 0 A, 1 B, 2 A and B, 3 ceiling |
| wr_data_a | input | 16 | Write data for A, for B alone, and for the ceiling |
| wr_data_b | input | 16 | B data when both thresholds are written together |
| count | output | 16 | Current counter value |
| out_a | output | 1 | Channel A PWM output |
| out_b | output | 1 | Channel B PWM output |

## Verification
The outputs are combinational from `count` and the working thresholds, so every effect appears one clock edge after its cause. The counter moves on the edge after `en` changes. A write made while stopped shows on the outputs right after the edge that captured it. A buffered write shows from the first counter value of the next period. The bench changes inputs and samples results at falling edges, and it counts each expected value edge by edge from a known counter position. For the buffered cases it samples the one counter value where the old and new settings give different outputs, such as the descending count of 1 in up/down mode, which tells a transfer at the ceiling apart from a transfer at zero.

// File: rtl/pwm_slice_pkg.sv
// Package: shared widths and encodings for the PWM slice.
// Assumes: the write selector encoding is fixed by the block's requirements.
package pwm_slice_pkg;

    localparam int CNT_W = 16;
    localparam int NCHAN = 2;
    localparam int NREG  = NCHAN + 1;

    // Indices into the shadow/working register bank
    localparam int IDX_TOP = 0;
    localparam int IDX_A   = 1;
    localparam int IDX_B   = 2;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_BOTH = 2'd2,
        SEL_TOP  = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/pwm_slice_counter.sv
// Module: pwm_slice_counter
// Generates the slice count in sawtooth or up/down form and flags the
// cycle in which shadow values may move into the working registers.
// Assumes: top is the working ceiling; en low freezes the count.
module pwm_slice_counter #(
    parameter int W = pwm_slice_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         phase_mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic         xfer
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic dir_down;

    // Advance the counter and its direction once per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_down <= 1'b0;
        end else if (en) begin
            if (!phase_mode) begin
                dir_down <= 1'b0;
                count    <= (count >= top) ? '0 : count + ONE;
            end else if (!dir_down && count < top) begin
                count <= count + ONE;
            end else if (count == '0) begin
                count    <= '0;
                dir_down <= 1'b0;
            end else begin
                count    <= count - ONE;
                dir_down <= (count != ONE);
            end
        end
    end

    // Transfer point: stopped, wrap (sawtooth) or zero (up/down)
    always_comb begin
        if (!en)
            xfer = 1'b1;
        else if (phase_mode)
            xfer = (count == '0);
        else
            xfer = (count >= top);
    end

endmodule

// File: rtl/pwm_slice_shadow.sv
// Module: pwm_slice_shadow
// Holds the shadow and working copies of the ceiling and the thresholds.
// Assumes: a write lands in the shadow copy; the working copy takes the
// shadow copy, including a same-cycle write, whenever xfer is high.
module pwm_slice_shadow #(
    parameter int W = pwm_slice_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data_a,
    input  logic [W-1:0] wr_data_b,
    input  logic         xfer,
    output logic [W-1:0] act_top,
    output logic [W-1:0] act_a,
    output logic [W-1:0] act_b
);

    import pwm_slice_pkg::*;

    logic [NREG-1:0]        load;
    logic [NREG-1:0][W-1:0] load_val;
    logic [NREG-1:0][W-1:0] shadow_q;
    logic [NREG-1:0][W-1:0] active_q;

    // Decode the write selector into per-register load strobes and data
    always_comb begin
        load              = '0;
        load_val[IDX_TOP] = wr_data_a;
        load_val[IDX_A]   = wr_data_a;
        load_val[IDX_B]   = (wr_sel_e'(wr_sel) == SEL_BOTH) ? wr_data_b : wr_data_a;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_A:    load[IDX_A]   = 1'b1;
                SEL_B:    load[IDX_B]   = 1'b1;
                SEL_BOTH: begin
                    load[IDX_A] = 1'b1;
                    load[IDX_B] = 1'b1;
                end
                default:  load[IDX_TOP] = 1'b1;
            endcase
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] nxt;

        // Next shadow value: a fresh write wins over the held one
        assign nxt = load[i] ? load_val[i] : shadow_q[i];

        // Update the shadow copy and, at a transfer point, the working copy
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                shadow_q[i] <= nxt;
                if (xfer)
                    active_q[i] <= nxt;
            end
        end
    end

    assign act_top = active_q[IDX_TOP];
    assign act_a   = active_q[IDX_A];
    assign act_b   = active_q[IDX_B];

endmodule

// File: rtl/pwm_slice_compare.sv
// Module: pwm_slice_compare
// One comparator per channel; an output is high while count < level.
// Assumes: levels are the working (already transferred) thresholds.
module pwm_slice_compare #(
    parameter int W   = pwm_slice_pkg::CNT_W,
    parameter int NCH = pwm_slice_pkg::NCHAN
) (
    input  logic [W-1:0]          count,
    input  logic [NCH-1:0][W-1:0] level,
    output logic [NCH-1:0]        pwm_out
);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Channel compare: asserted below the threshold
        assign pwm_out[c] = (count < level[c]);
    end

endmodule

// File: rtl/pwm_dual_slice.sv
// Module: pwm_dual_slice
// Two-channel PWM slice with double-buffered ceiling and thresholds.
// Assumes: single clock, synchronous active-low reset, one write per cycle.
module pwm_dual_slice #(
    parameter int W = pwm_slice_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         phase_mode,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data_a,
    input  logic [W-1:0] wr_data_b,
    output logic [W-1:0] count,
    output logic         out_a,
    output logic         out_b
);

    import pwm_slice_pkg::*;

    logic                     xfer;
    logic [W-1:0]             act_top;
    logic [W-1:0]             act_lvl_a;
    logic [W-1:0]             act_lvl_b;
    logic [NCHAN-1:0][W-1:0]  levels;
    logic [NCHAN-1:0]         pwm_q;

    pwm_slice_counter #(.W(W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .phase_mode (phase_mode),
        .top        (act_top),
        .count      (count),
        .xfer       (xfer)
    );

    pwm_slice_shadow #(.W(W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data_a  (wr_data_a),
        .wr_data_b  (wr_data_b),
        .xfer       (xfer),
        .act_top    (act_top),
        .act_a      (act_lvl_a),
        .act_b      (act_lvl_b)
    );

    assign levels = {act_lvl_b, act_lvl_a};

    pwm_slice_compare #(.W(W), .NCH(NCHAN)) u_compare (
        .count   (count),
        .level   (levels),
        .pwm_out (pwm_q)
    );

    assign out_a = pwm_q[0];
    assign out_b = pwm_q[1];

endmodule

// File: rtl/pwm_dual_slice_chk.sv
// Module: pwm_dual_slice_chk
// Property checker bound into pwm_dual_slice; observes ports and the
// working registers only.
module pwm_dual_slice_chk #(
    parameter int W = pwm_slice_pkg::CNT_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         phase_mode,
    input logic [W-1:0] count,
    input logic [W-1:0] act_top,
    input logic [W-1:0] act_a,
    input logic [W-1:0] act_b,
    input logic         out_a,
    input logic         out_b
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == $past(count))); // R10

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !phase_mode && count < act_top) |=> (count == $past(count) + ONE)); // R2

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !phase_mode && count >= act_top) |=> (count == '0)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_mode && count != '0) |=>
            (count == $past(count) + ONE || count == $past(count) - ONE)); // R4

    AST_LEVEL_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a == '0) |-> !out_a); // R3

    AST_ABOVE_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_b > act_top && count <= act_top) |-> out_b); // R3

    AST_FREE_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !phase_mode && count < act_top) |=>
            ($stable(act_top) && $stable(act_a) && $stable(act_b))); // R5

    AST_PHASE_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_mode && count != '0) |=>
            ($stable(act_top) && $stable(act_a) && $stable(act_b))); // R6

    AST_TOP_ZERO_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_top == '0 && count == '0) |=> (count == '0)); // R11

endmodule

bind pwm_dual_slice pwm_dual_slice_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .phase_mode (phase_mode),
    .count      (count),
    .act_top    (act_top),
    .act_a      (act_lvl_a),
    .act_b      (act_lvl_b),
    .out_a      (out_a),
    .out_b      (out_b)
);

// File: tb/pwm_dual_slice_bench.sv
// Directed bench for pwm_dual_slice: one task per scenario, inputs driven
// and outputs sampled at falling edges.
module pwm_dual_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        phase_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data_a = 16'd0;
    logic [15:0] wr_data_b = 16'd0;
    logic [15:0] count;
    logic        out_a;
    logic        out_b;

    int n_chk  = 0;
    int n_fail = 0;

    pwm_dual_slice u_pwm_dual_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .phase_mode (phase_mode),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data_a  (wr_data_a),
        .wr_data_b  (wr_data_b),
        .count      (count),
        .out_a      (out_a),
        .out_b      (out_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One-cycle write; called and returning at a falling edge
    task automatic do_write(input logic [1:0] sel, input logic [15:0] da,
                            input logic [15:0] db);
        wr_en     = 1'b1;
        wr_sel    = sel;
        wr_data_a = da;
        wr_data_b = db;
        step();
        wr_en     = 1'b0;
    endtask

    task automatic do_reset();
        en         = 1'b0;
        phase_mode = 1'b0;
        wr_en      = 1'b0;
        rst_n      = 1'b0;
        repeat (2) step();
        rst_n      = 1'b1;
    endtask

    // R1: cleared state after reset
    task automatic t_reset();
        do_reset();
        check("R1", "count after reset", 32'(count), 0);
        check("R1", "out_a after reset", 32'(out_a), 0);
        check("R1", "out_b after reset", 32'(out_b), 0);
    endtask

    // R7, R8, R3: writes while stopped act on the next edge; selector decode
    task automatic t_stopped_writes();
        do_write(2'd3, 16'd4, 16'd0);          // ceiling = 4
        do_write(2'd0, 16'd2, 16'd0);          // A = 2
        check("R7", "out_a right after A write while stopped", 32'(out_a), 1);
        check("R8", "B untouched by A-only write", 32'(out_b), 0);
        do_write(2'd1, 16'd5, 16'd0);          // B = 5 via data_a
        check("R8", "B written from wr_data_a", 32'(out_b), 1);
        check("R8", "A untouched by B-only write", 32'(out_a), 1);
        do_write(2'd2, 16'd0, 16'd0);          // both = 0
        check("R3", "A threshold 0 keeps out_a low", 32'(out_a), 0);
        check("R8", "both write clears B", 32'(out_b), 0);
        do_write(2'd2, 16'd2, 16'd5);          // A = 2, B = 5
        check("R8", "both write sets A from data_a", 32'(out_a), 1);
        check("R8", "both write sets B from data_b", 32'(out_b), 1);
        check("R10", "count frozen while stopped", 32'(count), 0);
    endtask

    // R2, R3: sawtooth with ceiling 4, A = 2, B = 5 (> ceiling)
    task automatic t_free_run();
        en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            check("R2", "sawtooth count", 32'(count), 32'(i % 5));
            check("R3", "out_a vs threshold 2", 32'(out_a), 32'((i % 5) < 2));
            check("R3", "out_b with threshold above ceiling", 32'(out_b), 1);
            step();
        end
    endtask

    // R5: ceiling written mid-period applies only after the wrap
    task automatic t_free_buffered_top();
        int exp_seq [10] = '{1, 2, 3, 4, 0, 1, 2, 0, 1, 2};
        check("R5", "count at start of buffer test", 32'(count), 0);
        do_write(2'd3, 16'd2, 16'd0);          // ceiling = 2, buffered
        for (int i = 0; i < 10; i++) begin
            check("R5", "ceiling change waits for wrap", 32'(count), 32'(exp_seq[i]));
            step();
        end
    endtask

    // R9, R5: write on the transfer cycle vs write mid-period (ceiling 2)
    task automatic t_coincident_write();
        while (count != 16'd2) step();
        do_write(2'd0, 16'd1, 16'd0);          // A = 1 on the wrap cycle
        check("R9", "count after wrap", 32'(count), 0);
        check("R9", "out_a at count 0 with new A=1", 32'(out_a), 1);
        do_write(2'd1, 16'd1, 16'd0);          // B = 1 mid-period
        check("R9", "new A=1 used at count 1", 32'(out_a), 0);
        check("R5", "old B still used at count 1", 32'(out_b), 1);
        step();
        check("R5", "old B still used at count 2", 32'(out_b), 1);
        step();
        check("R5", "count after next wrap", 32'(count), 0);
        step();
        check("R5", "new B=1 used at count 1", 32'(out_b), 0);
    endtask

    // R10: clearing en freezes the counter; counting resumes from it
    task automatic t_hold();
        logic [15:0] held;
        held = count;
        en   = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R10", "count held while disabled", 32'(count), 32'(held));
        end
        en = 1'b1;
        step();
        check("R10", "count resumes from held value", 32'(count),
              (held == 16'd2) ? 32'd0 : 32'(held) + 32'd1);
    endtask

    // R4, R6: up/down with ceiling 3, A = 2, B = 4
    task automatic t_phase();
        int tri_seq [6] = '{0, 1, 2, 3, 2, 1};
        do_reset();
        do_write(2'd3, 16'd3, 16'd0);
        do_write(2'd2, 16'd2, 16'd4);
        phase_mode = 1'b1;
        en         = 1'b1;
        for (int i = 0; i < 12; i++) begin
            check("R4", "up/down count", 32'(count), 32'(tri_seq[i % 6]));
            check("R4", "centred out_a", 32'(out_a), 32'(tri_seq[i % 6] < 2));
            check("R3", "out_b with threshold above ceiling", 32'(out_b), 1);
            step();
        end
        check("R4", "count back at 0 after two periods", 32'(count), 0);
        step();
        check("R6", "count 1 before buffered write", 32'(count), 1);
        do_write(2'd0, 16'd1, 16'd0);          // A = 1 while climbing
        check("R6", "count 2 rising", 32'(count), 2);
        step();
        check("R6", "count at ceiling", 32'(count), 3);
        step();
        step();
        check("R6", "descending count 1", 32'(count), 1);
        check("R6", "no transfer at ceiling: old A still used", 32'(out_a), 1);
        step();
        check("R6", "count at 0", 32'(count), 0);
        step();
        check("R6", "transfer at zero: new A used at count 1", 32'(out_a), 0);
    endtask

    // R11: ceiling 0 keeps the counter at 0 in both modes
    task automatic t_top_zero();
        do_reset();
        en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R11", "sawtooth with ceiling 0", 32'(count), 0);
        end
        phase_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R11", "up/down with ceiling 0", 32'(count), 0);
        end
        check("R1", "outputs low with zero thresholds", 32'({out_a, out_b}), 0);
    endtask

    initial begin
        step();
        t_reset();
        t_stopped_writes();
        t_free_run();
        t_free_buffered_top();
        t_coincident_write();
        t_hold();
        t_phase();
        t_top_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", WD_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule